// File: doc/BRIEF.md
# FIFO Status Flag Generator

This block turns occupancy counts into the five active-low status outputs of a dual-clock FIFO. The write domain supplies its own occupancy figure, built from its pointer and the synchronised read pointer. The read domain supplies the matching figure from its side. Because each figure lags the other domain's activity, the flags err on the safe side. Two programmable offsets set the almost thresholds: the empty offset `n` and the full offset `m`.

The block has two timing modes, chosen by a static mode input. In standard mode the occupancy counts the words held in storage, up to `DEPTH`. In fall-through mode the count also includes the word waiting in the output register, up to `DEPTH+1`. In that mode every threshold moves up by one word, and the full and empty outputs take the opposite sense, as input-ready and output-ready. Each domain has its own synchronous active-low reset, which puts that domain's flags into their empty-FIFO values for the mode.

The near-full and space outputs live in the write clock domain. The near-empty and data outputs live in the read clock domain. A parameter places the half-full output in either domain.

Top module: `fifo_status_flags`

## Requirements
- R1: In standard mode (`fall_through`=0), `near_empty_n` is 0 while the read occupancy is at most `empty_ofs`, and 1 from `empty_ofs`+1 words upward.
- R2: In fall-through mode (`fall_through`=1), `near_empty_n` is 0 while the read occupancy is at most `empty_ofs`+1, and 1 from `empty_ofs`+2 words upward.
- R3: `near_full_n` is 0 when the write occupancy is at least `DEPTH`−`full_ofs` in standard mode, or at least `DEPTH`+1−`full_ofs` in fall-through mode, and 1 otherwise.
- R4: `half_n` is 0 when the occupancy is at least `DEPTH`/2+1 in standard mode, or at least `DEPTH`/2+2 in fall-through mode, and 1 otherwise.
- R5: In standard mode, `space_flag` is 0 when the write occupancy is at least `DEPTH` (full) and 1 otherwise. `data_flag` is 0 when the read occupancy is 0 (empty) and 1 otherwise.
- R6: In fall-through mode, `space_flag` is 1 when the write occupancy is at least `DEPTH`+1 (no room) and 0 otherwise. `data_flag` is 1 when the read occupancy is 0 (no valid output word) and 0 otherwise.
- R7: The latencies from a sampled occupancy to the outputs are fixed:
  - `near_empty_n`, `near_full_n` and `half_n` follow one clock later.
  - `space_flag` follows two clocks later.
  - `data_flag` follows two clocks later in standard mode and three clocks later in fall-through mode.
- R8: While a domain's reset is low at a clock edge, the next output values of that domain are the empty-FIFO values for the mode:
  - `near_empty_n`=0, `near_full_n`=1 and `half_n`=1.
  - `space_flag`=1 and `data_flag`=0 in standard mode.
  - `space_flag`=0 and `data_flag`=1 in fall-through mode.
- R9: `near_full_n` and `space_flag` depend only on `wr_level` and `wclk`. `near_empty_n` and `data_flag` depend only on `rd_level` and `rclk`. `half_n` depends on `wr_level` and `wclk` when `HF_ON_READ`=0, and on `rd_level` and `rclk` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write domain clock |
| wrst_n | input | 1 | Write domain synchronous reset, active low |
| wr_level | input | LW | Occupancy as seen by the write domain |
| rclk | input | 1 | Read domain clock |
| rrst_n | input | 1 | Read domain synchronous reset, active low |
| rd_level | input | LW | Occupancy as seen by the read domain |
| fall_through | input | 1 | Timing mode: 0 standard, 1 fall-through; changed only under reset |
| empty_ofs | input | OW | Almost-empty offset n |
| full_ofs | input | OW | Almost-full offset m |
| space_flag | output | 1 | Full (low, standard) or no-room (high, fall-through) |
| near_full_n | output | 1 | Almost-full, active low |
| half_n | output | 1 | Half-full, active low |
| near_empty_n | output | 1 | Almost-empty, active low |
| data_flag | output | 1 | Empty (low, standard) or no-output-word (high, fall-through) |

## Verification
A single step of the occupancy count can cross the almost threshold and the hard full or empty boundary in the same edge. Example: the count jumps from 0 to `DEPTH`, or from `DEPTH`+1 down to 0. The bench provokes this with directed jumps, and also with random counts drawn around every threshold at once. It judges each output separately against its own latency: the almost and half flags must move one clock after the step, while `space_flag` and `data_flag` must hold their old value for one or two more clocks. This shows that the shorter path never leaks into the longer pipeline.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FALL = 1'b1
    } mode_e;
endpackage

// File: rtl/fifo_flag_pipe.sv
module fifo_flag_pipe #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_val,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sr[0] <= rst_val;
                    else        sr[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sr[i] <= rst_val;
                    else        sr[i] <= sr[i-1];
                end
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/fifo_flag_wside.sv
module fifo_flag_wside
    import fifo_flag_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int LW    = $clog2(DEPTH + 2),
    localparam int OW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic [LW-1:0] level,
    input  logic [OW-1:0] full_ofs,
    output logic          near_full_n,
    output logic          space_flag
);
    localparam int CW = LW + 1;

    logic [CW-1:0] lvl_x;
    logic [CW-1:0] full_lim;
    logic [CW-1:0] nf_lim;
    logic          nf_raw;
    logic          sp_raw;
    logic          sp_rst;

    assign lvl_x = CW'(level);

    always_comb begin
        unique case (mode)
            MODE_STD: begin
                full_lim = CW'(DEPTH);
                nf_lim   = CW'(DEPTH) - CW'(full_ofs);
                sp_raw   = !(lvl_x >= full_lim);
            end
            MODE_FALL: begin
                full_lim = CW'(DEPTH + 1);
                nf_lim   = CW'(DEPTH + 1) - CW'(full_ofs);
                sp_raw   = (lvl_x >= full_lim);
            end
        endcase
        nf_raw = !(lvl_x >= nf_lim);
    end

    assign sp_rst = (mode == MODE_STD);

    fifo_flag_pipe #(.STAGES(1)) u_nf_pipe (
        .clk(clk), .rst_n(rst_n), .rst_val(1'b1), .d(nf_raw), .q(near_full_n)
    );

    fifo_flag_pipe #(.STAGES(2)) u_sp_pipe (
        .clk(clk), .rst_n(rst_n), .rst_val(sp_rst), .d(sp_raw), .q(space_flag)
    );

    assert_near_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (int'($past(level)) + int'(full_ofs) >= DEPTH + int'(mode)))
        |-> !near_full_n);

    assert_full_std_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD && $past(rst_n) && $past(rst_n, 2) && int'($past(level, 2)) >= DEPTH)
        |-> !space_flag);

    assert_wreset_R8: assert property (@(posedge clk)
        !rst_n |=> near_full_n);
endmodule

// File: rtl/fifo_flag_rside.sv
module fifo_flag_rside
    import fifo_flag_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int LW    = $clog2(DEPTH + 2),
    localparam int OW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic [LW-1:0] level,
    input  logic [OW-1:0] empty_ofs,
    output logic          near_empty_n,
    output logic          data_flag
);
    localparam int CW = LW + 1;

    logic [CW-1:0] lvl_x;
    logic [CW-1:0] ne_lim;
    logic          ne_raw;
    logic          df_raw;
    logic          df_rst;
    logic          df_two;
    logic          df_three;

    assign lvl_x = CW'(level);

    always_comb begin
        unique case (mode)
            MODE_STD: begin
                ne_lim = CW'(empty_ofs);
                df_raw = (lvl_x != '0);
            end
            MODE_FALL: begin
                ne_lim = CW'(empty_ofs) + CW'(1);
                df_raw = (lvl_x == '0);
            end
        endcase
        ne_raw = (lvl_x > ne_lim);
    end

    assign df_rst = (mode == MODE_FALL);

    fifo_flag_pipe #(.STAGES(1)) u_ne_pipe (
        .clk(clk), .rst_n(rst_n), .rst_val(1'b0), .d(ne_raw), .q(near_empty_n)
    );

    fifo_flag_pipe #(.STAGES(2)) u_df_pipe (
        .clk(clk), .rst_n(rst_n), .rst_val(df_rst), .d(df_raw), .q(df_two)
    );

    fifo_flag_pipe #(.STAGES(1)) u_df_extra (
        .clk(clk), .rst_n(rst_n), .rst_val(df_rst), .d(df_two), .q(df_three)
    );

    assign data_flag = (mode == MODE_FALL) ? df_three : df_two;

    assert_near_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD && $past(rst_n) && int'($past(level)) <= int'(empty_ofs))
        |-> !near_empty_n);

    assert_near_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FALL && $past(rst_n) && int'($past(level)) == int'(empty_ofs) + 1)
        |-> !near_empty_n);

    assert_ready_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FALL && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)
         && $past(level, 3) == '0) |-> data_flag);

    assert_rreset_R8: assert property (@(posedge clk)
        !rst_n |=> !near_empty_n);
endmodule

// File: rtl/fifo_flag_half.sv
module fifo_flag_half
    import fifo_flag_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int LW    = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic [LW-1:0] level,
    output logic          half_n
);
    localparam int CW = LW + 1;

    logic [CW-1:0] half_lim;
    logic          half_raw;

    always_comb begin
        unique case (mode)
            MODE_STD:  half_lim = CW'(DEPTH / 2 + 1);
            MODE_FALL: half_lim = CW'(DEPTH / 2 + 2);
        endcase
        half_raw = !(CW'(level) >= half_lim);
    end

    fifo_flag_pipe #(.STAGES(1)) u_half_pipe (
        .clk(clk), .rst_n(rst_n), .rst_val(1'b1), .d(half_raw), .q(half_n)
    );

    assert_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && int'($past(level)) > DEPTH / 2 + int'(mode)) |-> !half_n);
endmodule

// File: rtl/fifo_status_flags.sv
module fifo_status_flags
    import fifo_flag_pkg::*;
#(
    parameter  int DEPTH      = 256,
    parameter  bit HF_ON_READ = 1'b0,
    localparam int LW         = $clog2(DEPTH + 2),
    localparam int OW         = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic [LW-1:0] wr_level,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic [LW-1:0] rd_level,
    input  logic          fall_through,
    input  logic [OW-1:0] empty_ofs,
    input  logic [OW-1:0] full_ofs,
    output logic          space_flag,
    output logic          near_full_n,
    output logic          half_n,
    output logic          near_empty_n,
    output logic          data_flag
);
    mode_e mode;
    assign mode = mode_e'(fall_through);

    fifo_flag_wside #(.DEPTH(DEPTH)) u_wside (
        .clk(wclk), .rst_n(wrst_n), .mode(mode), .level(wr_level),
        .full_ofs(full_ofs), .near_full_n(near_full_n), .space_flag(space_flag)
    );

    fifo_flag_rside #(.DEPTH(DEPTH)) u_rside (
        .clk(rclk), .rst_n(rrst_n), .mode(mode), .level(rd_level),
        .empty_ofs(empty_ofs), .near_empty_n(near_empty_n), .data_flag(data_flag)
    );

    generate
        if (HF_ON_READ) begin : g_half_rd
            fifo_flag_half #(.DEPTH(DEPTH)) u_half (
                .clk(rclk), .rst_n(rrst_n), .mode(mode), .level(rd_level), .half_n(half_n)
            );
        end else begin : g_half_wr
            fifo_flag_half #(.DEPTH(DEPTH)) u_half (
                .clk(wclk), .rst_n(wrst_n), .mode(mode), .level(wr_level), .half_n(half_n)
            );
        end
    endgenerate

    assert_level_range_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
        int'(wr_level) <= DEPTH + 1);
endmodule

// File: tb/fifo_status_flags_tb.sv
`timescale 1ns/1ps
module fifo_status_flags_tb;
    localparam int DEPTH = 256;
    localparam int LW    = $clog2(DEPTH + 2);
    localparam int OW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          wrst_n = 1'b0;
    logic          rrst_n = 1'b0;
    logic [LW-1:0] wr_level = '0;
    logic [LW-1:0] rd_level = '0;
    logic          fall = 1'b0;
    logic [OW-1:0] n_ofs = OW'(20);
    logic [OW-1:0] m_ofs = OW'(30);
    logic          space_flag, near_full_n, half_n, near_empty_n, data_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int wlh [3];
    int rlh [3];
    bit wrh [3];
    bit rrh [3];

    always #2.5 clk = ~clk;

    fifo_status_flags #(.DEPTH(DEPTH)) u_dut (
        .wclk(clk), .wrst_n(wrst_n), .wr_level(wr_level),
        .rclk(clk), .rrst_n(rrst_n), .rd_level(rd_level),
        .fall_through(fall), .empty_ofs(n_ofs), .full_ofs(m_ofs),
        .space_flag(space_flag), .near_full_n(near_full_n), .half_n(half_n),
        .near_empty_n(near_empty_n), .data_flag(data_flag)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string name);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b (wl=%0d rl=%0d mode=%0b)",
                     tag, name, act, exp, wlh[0], rlh[0], fall);
        end
    endtask

    // Expected values derived from R1..R8, with per-output latency (R7)
    task automatic check_all();
        int  f;
        bit  e;
        int  s;
        bit  any_rst;
        f = int'(fall);
        // near-empty: R1 / R2, read domain only (R9)
        e = rrh[0] ? (rlh[0] > int'(n_ofs) + f) : 1'b0;
        check(near_empty_n, e, fall ? "R2 R9" : "R1 R9", "near_empty_n");
        // near-full: R3
        e = wrh[0] ? !(wlh[0] >= DEPTH + f - int'(m_ofs)) : 1'b1;
        check(near_full_n, e, wrh[0] ? "R3" : "R8", "near_full_n");
        // half: R4 (write domain by default)
        e = wrh[0] ? !(wlh[0] >= DEPTH / 2 + 1 + f) : 1'b1;
        check(half_n, e, wrh[0] ? "R4" : "R8", "half_n");
        // space flag: R5 / R6 with two-cycle latency R7
        if (!wrh[0] || !wrh[1]) begin
            e = fall ? 1'b0 : 1'b1;
            check(space_flag, e, "R8", "space_flag");
        end else begin
            e = (wlh[1] >= DEPTH + f);
            if (!fall) e = !e;
            check(space_flag, e, fall ? "R6 R7" : "R5 R7", "space_flag");
        end
        // data flag: R5 / R6 with two or three cycle latency R7
        s = fall ? 3 : 2;
        any_rst = 1'b0;
        for (int i = 0; i < s; i++) if (!rrh[i]) any_rst = 1'b1;
        if (any_rst) begin
            check(data_flag, fall, "R8", "data_flag");
        end else begin
            e = (rlh[s-1] == 0);
            if (!fall) e = !e;
            check(data_flag, e, fall ? "R6 R7" : "R5 R7", "data_flag");
        end
    endtask

    task automatic step(input int wl, input int rl, input bit wr, input bit rr);
        wr_level = LW'(wl);
        rd_level = LW'(rl);
        wrst_n = wr;
        rrst_n = rr;
        @(posedge clk);
        for (int i = 2; i > 0; i--) begin
            wlh[i] = wlh[i-1]; rlh[i] = rlh[i-1];
            wrh[i] = wrh[i-1]; rrh[i] = rrh[i-1];
        end
        wlh[0] = wl; rlh[0] = rl; wrh[0] = wr; rrh[0] = rr;
        @(negedge clk);
        check_all();
    endtask

    function automatic int pick();
        int c [8];
        int f;
        int v;
        f = int'(fall);
        c[0] = 0;
        c[1] = int'(n_ofs) + f;
        c[2] = int'(n_ofs) + f + 1;
        c[3] = DEPTH / 2 + f;
        c[4] = DEPTH / 2 + 1 + f;
        c[5] = DEPTH + f - int'(m_ofs);
        c[6] = DEPTH + f;
        c[7] = int'($urandom % (DEPTH + 2));
        v = c[$urandom % 8] + int'($urandom % 3) - 1;
        if (v < 0) v = 0;
        if (v > DEPTH + f) v = DEPTH + f;
        return v;
    endfunction

    // Mode and offsets change only while both domains are in reset (R8)
    task automatic reset_into(input bit mode, input int n, input int m);
        fall = mode;
        n_ofs = OW'(n);
        m_ofs = OW'(m);
        for (int i = 0; i < 4; i++) step(pick(), pick(), 1'b0, 1'b0);
    endtask

    task automatic random_run(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            // R9: write and read counts drawn independently
            step(pick(), pick(), 1'b1, 1'b1);
        end
    endtask

    initial begin
        void'($urandom(32'd7741));
        for (int i = 0; i < 3; i++) begin
            wlh[i] = 0; rlh[i] = 0; wrh[i] = 1'b0; rrh[i] = 1'b0;
        end
        @(negedge clk);

        // Standard mode, directed thresholds (R1 R3 R4 R5 R7)
        reset_into(1'b0, 20, 30);
        step(0, 0, 1'b1, 1'b1);
        step(20, 20, 1'b1, 1'b1);
        step(21, 21, 1'b1, 1'b1);
        step(128, 1, 1'b1, 1'b1);
        step(129, 0, 1'b1, 1'b1);
        step(225, 0, 1'b1, 1'b1);
        step(226, 5, 1'b1, 1'b1);
        step(255, 5, 1'b1, 1'b1);
        step(256, 5, 1'b1, 1'b1);
        // same-cycle jumps: almost flag moves first, full/empty follow later (R7)
        step(0, 256, 1'b1, 1'b1);
        step(256, 0, 1'b1, 1'b1);
        step(256, 0, 1'b1, 1'b1);
        step(0, 0, 1'b1, 1'b1);
        random_run(300);
        // reset in mid-run with non-zero counts (R8), write domain alone
        step(200, 200, 1'b0, 1'b1);
        step(200, 200, 1'b1, 1'b1);
        step(200, 200, 1'b1, 1'b1);

        // Fall-through mode, boundary offsets (R2 R3 R4 R6 R7)
        reset_into(1'b1, 0, 1);
        step(0, 0, 1'b1, 1'b1);
        step(1, 1, 1'b1, 1'b1);
        step(2, 2, 1'b1, 1'b1);
        step(129, 0, 1'b1, 1'b1);
        step(130, 0, 1'b1, 1'b1);
        step(256, 0, 1'b1, 1'b1);
        step(257, 257, 1'b1, 1'b1);
        step(0, 0, 1'b1, 1'b1);
        step(257, 0, 1'b1, 1'b1);
        step(0, 9, 1'b1, 1'b1);
        step(0, 0, 1'b1, 1'b1);
        step(0, 0, 1'b1, 1'b1);
        step(0, 0, 1'b1, 1'b1);
        random_run(300);
        // read-domain reset alone (R8)
        step(10, 10, 1'b1, 1'b0);
        step(10, 10, 1'b1, 1'b1);
        step(10, 10, 1'b1, 1'b1);
        step(10, 10, 1'b1, 1'b1);

        // Standard mode, largest offsets
        reset_into(1'b0, DEPTH - 1, DEPTH - 1);
        random_run(200);
        reset_into(1'b1, DEPTH - 1, DEPTH - 1);
        random_run(200);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule